// File: doc/BRIEF.md
# Set/Clear Interrupt Event and Mask Register

This block holds a vector of sticky interrupt event flags and a matching enable mask, both reachable from a simple memory-mapped slave port. Neither register is written directly. Each has a "set" address, where every 1 in the written word turns the matching bit on, and a "clear" address, where every 1 turns the matching bit off. Bits written as 0 are left alone. Because of this, software can acknowledge one event without a read-modify-write, and so it cannot race hardware that is setting other bits.

Internal event sources are level signals. An event flag is raised on the rising edge of its source. After that the flag stays on, even if the source is still high, until software clears it. The mask register is one bit wider than the event vector. Its top bit is a master enable, and its lower bits enable the events one for one. The interrupt line is asserted when the master enable is on and at least one enabled event is pending.

The two event addresses return different views. The set address reads back the raw event flags. The clear address reads back only the events that the mask lets through.

Top module: `intr_event_ctrl`

## Requirements
- R1: While reset is active and after it is released, the event flags and the mask (including the master enable) are all zero, `irq_o` is low, and a read of any of the four addresses returns 0.
- R2: A write to address 0 (event set) turns on every event flag whose `wdata_i` bit is 1 and leaves every other flag unchanged.
- R3: A write to address 1 (event clear) turns off every event flag whose `wdata_i` bit is 1 and leaves every other flag unchanged. Clearing is the only way a flag goes low.
- R4: When `src_i[n]` goes from 0 to 1, event flag n is on after that clock edge. A source held high raises the flag once only, so a flag cleared while its source is still high stays clear.
- R5: A flag that is on stays on when its source falls.
- R6: If a rising edge of `src_i[n]` and a clear write with bit n set reach the same clock edge, flag n ends up on.
- R7: A read of address 0 returns the event flags in bits 30:0. A read of address 1 returns the flags ANDed with mask bits 30:0. Bit 31 reads as 0 at both addresses.
- R8: A write to address 2 (mask set) or address 3 (mask clear) updates all 32 mask bits by the same rules as R2 and R3. Bit 31 is the master enable. A read of address 2 or 3 returns the whole mask.
- R9: `irq_o` is 1 exactly when mask bit 31 is 1 and at least one bit of (flags AND mask[30:0]) is 1. It follows register changes with no added latency.
- R10: `rdata_o` takes the value selected by `addr_i` on the clock edge where `rd_en_i` is high. The value shows the registers as they were before that edge, and `rdata_o` holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe for one cycle |
| addr_i | input | 2 | Register select: 0 event set, 1 event clear, 2 mask set, 3 mask clear |
| wdata_i | input | 32 | Write data; its 1 bits act on the selected register |
| src_i | input | 31 | Level event sources, edge-detected |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a source edge that lands on the very clock edge of a clear write for the same bit. A second hard case is a clear issued while the source is still held high, since a naive level-set design would re-raise that flag. The stimulus drives the source transition and the clear write on the same falling edge, so both reach one rising edge together. It then reads the flag back through the raw-view address. The random phase also mixes source toggles with clear writes of broad bit patterns, so that these collisions recur across many bit positions. A behavioural model checks every cycle.

// File: rtl/intr_sc_pkg.sv
package intr_sc_pkg;
  // Register select codes on the slave address
  typedef enum logic [1:0] {
    SEL_EVT_SET = 2'd0,
    SEL_EVT_CLR = 2'd1,
    SEL_MSK_SET = 2'd2,
    SEL_MSK_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_edge_det.sv
module intr_edge_det #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= src[i];
    end
    assign rise[i] = src[i] & ~prev_q[i];

    // R4: a held level yields a single pulse
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/intr_sc_reg.sv
module intr_sc_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  // hardware set dominates a same-cycle software clear
  function automatic logic [W-1:0] sc_next(input logic [W-1:0] cur,
                                            input logic [W-1:0] set_m,
                                            input logic [W-1:0] clr_m,
                                            input logic [W-1:0] hw_m);
    return (cur & ~clr_m) | set_m | hw_m;
  endfunction

  logic [W-1:0] set_mask, clr_mask;
  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= sc_next(q, set_mask, clr_mask, hw_set);
  end

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata)) == $past(wdata)));
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(q) & ~q) == '0));
  p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/intr_event_ctrl.sv
module intr_event_ctrl
  import intr_sc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-2:0] src_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int NE  = DW - 1;
  localparam int MEN = DW - 1;

  reg_sel_e     sel;
  logic         evt_set_we, evt_clr_we, msk_set_we, msk_clr_we;
  logic [NE-1:0] evt_rise, evt_q;
  logic [DW-1:0] msk_q;
  logic [NE-1:0] pending;
  logic [DW-1:0] rd_view;

  function automatic logic [DW-1:0] read_view(input reg_sel_e s,
                                               input logic [NE-1:0] ev,
                                               input logic [DW-1:0] mk);
    case (s)
      SEL_EVT_SET: return {1'b0, ev};
      SEL_EVT_CLR: return {1'b0, ev & mk[NE-1:0]};
      default:     return mk;
    endcase
  endfunction

  assign sel        = reg_sel_e'(addr_i);
  assign evt_set_we = wr_en_i && (sel == SEL_EVT_SET);
  assign evt_clr_we = wr_en_i && (sel == SEL_EVT_CLR);
  assign msk_set_we = wr_en_i && (sel == SEL_MSK_SET);
  assign msk_clr_we = wr_en_i && (sel == SEL_MSK_CLR);

  intr_edge_det #(.W(NE)) u_edge (
    .clk(clk_i), .rst_n(rst_ni), .src(src_i), .rise(evt_rise)
  );

  intr_sc_reg #(.W(NE)) u_evt (
    .clk(clk_i), .rst_n(rst_ni), .set_we(evt_set_we), .clr_we(evt_clr_we),
    .wdata(wdata_i[NE-1:0]), .hw_set(evt_rise), .q(evt_q)
  );

  intr_sc_reg #(.W(DW)) u_msk (
    .clk(clk_i), .rst_n(rst_ni), .set_we(msk_set_we), .clr_we(msk_clr_we),
    .wdata(wdata_i), .hw_set('0), .q(msk_q)
  );

  assign pending = evt_q & msk_q[NE-1:0];
  assign irq_o   = msk_q[MEN] & (|pending);
  assign rd_view = read_view(sel, evt_q, msk_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_view;
  end

  p_irq_has_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (evt_q != '0));
  p_clr_view_msb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd1) |=> (rdata_o[MEN] == 1'b0));
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  p_edge_raises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0 && $past(src_i) == '0) |=> (evt_q != '0));
endmodule

// File: tb/sim_intr_event_ctrl.sv
module sim_intr_event_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [30:0] src = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_event_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .src_i(src), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [30:0] m_evt, m_prev;
  bit [31:0] m_msk, m_rd;
  int        m_last_sel = 0;

  always @(posedge clk) begin
    bit [30:0] edges;
    if (!rst_n) begin
      m_evt = 0; m_prev = 0; m_msk = 0; m_rd = 0;
    end else begin
      edges = src & ~m_prev;
      if (rd) begin
        m_last_sel = addr;
        if (addr == 0)      m_rd = {1'b0, m_evt};
        else if (addr == 1) m_rd = {1'b0, m_evt & m_msk[30:0]};
        else                m_rd = m_msk;
      end
      if (wr && addr == 0) m_evt = m_evt | wdata[30:0];
      if (wr && addr == 1) m_evt = m_evt & ~wdata[30:0];
      m_evt = m_evt | edges;
      if (wr && addr == 2) m_msk = m_msk | wdata;
      if (wr && addr == 3) m_msk = m_msk & ~wdata;
      m_prev = src;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 irq", {31'b0, irq},
            {31'b0, m_msk[31] & (|(m_evt & m_msk[30:0]))});
      check(m_last_sel < 2 ? "R7 rdata" : "R8 rdata", rdata, m_rd);
    end
  end

  task automatic write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic readv(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      readv(a[1:0], v); check("R1 post-reset read", v, 32'h0);
    end

    write(2'd0, 32'h0000_00F0);
    readv(2'd0, v); check("R2 event set", v, 32'h0000_00F0);
    readv(2'd1, v); check("R7 masked view mask=0", v, 32'h0);
    write(2'd1, 32'h0000_0030);
    readv(2'd0, v); check("R3 event clear", v, 32'h0000_00C0);

    write(2'd2, 32'h8000_0040);
    readv(2'd3, v); check("R8 mask via clr addr", v, 32'h8000_0040);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    readv(2'd1, v); check("R7 masked view", v, 32'h0000_0040);
    write(2'd3, 32'h8000_0000);
    check("R9 irq master off", {31'b0, irq}, 32'h0);
    readv(2'd2, v); check("R8 mask after clr", v, 32'h0000_0040);

    // R4: edge then held level
    @(negedge clk); src[3] = 1'b1;
    readv(2'd0, v); check("R4 edge sets", v & 32'h8, 32'h8);
    write(2'd1, 32'h0000_0008);
    repeat (3) @(negedge clk);
    readv(2'd0, v); check("R4 held level no re-set", v & 32'h8, 32'h0);
    // R5: flag survives source fall
    @(negedge clk); src[5] = 1'b1; src[3] = 1'b0;
    @(negedge clk); src[5] = 1'b0;
    repeat (2) @(negedge clk);
    readv(2'd0, v); check("R5 sticky after fall", v & 32'h20, 32'h20);
    // R6: edge and clear together
    @(negedge clk); src[9] = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 32'h0000_0200;
    @(negedge clk); wr = 1'b0; wdata = '0; src[9] = 1'b0;
    readv(2'd0, v); check("R6 edge beats clear", v & 32'h200, 32'h200);
    // R10: rdata holds without a read
    write(2'd0, 32'h7FFF_FFFF);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", rdata, v);

    // random mix
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wr = ($urandom_range(0, 2) == 0);
      rd = ($urandom_range(0, 1) == 0);
      addr = 2'($urandom_range(0, 3));
      wdata = $urandom;
      if ($urandom_range(0, 2) == 0) src = src ^ (31'(1) << $urandom_range(0, 30));
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule